// File: doc/BRIEF.md
# External Interrupt Input Conditioner

This block sits between a handful of external interrupt request pins and a processor's interrupt controller. It brings each pin into the clock domain and decides, line by line, whether the line is active. The decision uses a selectable polarity and, where the line supports it, a choice of edge or level detection. It drives one pending flag per line. Priority, masking and vectoring are handled downstream.

Software programs the block through a small synchronous register port with address, write enable and data. The port reaches a 16-bit control word and an edge status word. The control word packs one polarity bit per line and one mode bit per edge-capable line, at fixed positions. A captured edge stays pending until software writes 1 to the status bit of that line. A level request follows the synchronized pin, so it can only be removed at its external source.

There are five lines. Lines 0 to 3 can use either edge or level detection. Line 4 is always level-sensitive.

Top module: `irq_cond`

## Requirements
- R1: After reset, the control word reads 0x0000 and the status word reads 0x0000. All lines are level-sensitive with negative polarity, so `pend_o` is 0 while every pin is high.
- R2: The control word is at address 0. Bits 15 to 7 are read/write. Bits 6 to 0 always read 0 and ignore writes.
- R3: Line k (k = 0..3) takes its polarity from control bit 15-k, and line 4 takes its polarity from bit 7. A polarity bit of 1 means positive and 0 means negative. In level mode, `pend_o[k]` is 1 while the pin equals its polarity bit. It follows a pin change two clock edges after the change.
- R4: Line k (k = 0..3) is in edge mode when control bit 11-k is 1. With positive polarity, a low-to-high pin change sets status bit k. `pend_o[k]` then rises on the third clock edge after the pin change. A high-to-low change sets nothing.
- R5: In edge mode with negative polarity, a high-to-low pin change sets status bit k and a low-to-high change sets nothing.
- R6: The status word is at address 1, with bit k for line k (k = 0..3) and the upper bits reading 0. A set bit holds until a write to address 1 carries 1 in that bit. Writing 0 leaves the bit unchanged. In edge mode, `pend_o[k]` equals status bit k.
- R7: Writes to the status word never change the pending flag of a line in level mode.
- R8: If a qualifying edge and a write-1 clear of the same status bit land on the same clock edge, the bit stays set.
- R9: A write to the control word never sets a status bit by itself. Flipping the polarity of a quiet edge-mode line leaves it not pending.
- R10: Line 4 has no mode bit and stays level-sensitive whatever is written to bits 11 to 8.
- R11: A line in level mode never sets its status bit, however its pin toggles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| irq_i | input | 5 | External interrupt pins, asynchronous |
| addr_i | input | ADDR_W (2) | Register address: 0 control, 1 status |
| we_i | input | 1 | Write enable for the addressed register |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data of the addressed register, combinational |
| pend_o | output | 5 | Conditioned request, one per line |

## Verification
The bench builds the block with its defaults: two-bit address, two synchronizer stages and the fixed five-line layout. At that size every pin pattern can be swept in both polarities. Each edge-capable line is walked through both polarities, including the wrong-direction edge and a polarity flip while the pin is quiet. The two-stage synchronizer makes the two- and three-edge latencies exact. That exactness lets the bench place an edge precisely on the clock edge of a clear and check that the set survives.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;
  localparam int unsigned CTRL_W     = 16;
  localparam int unsigned NUM_LINES  = 5;
  localparam int unsigned NUM_EDGE   = 4;
  localparam int unsigned LVL_POL_HI = 7;

  function automatic int unsigned pol_idx(input int unsigned l);
    return (l < NUM_EDGE) ? (CTRL_W - 1 - l) : (LVL_POL_HI - (l - NUM_EDGE));
  endfunction

  function automatic int unsigned mode_idx(input int unsigned l);
    return CTRL_W - 1 - NUM_EDGE - l;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_mask();
    logic [CTRL_W-1:0] m;
    m = '0;
    for (int unsigned l = 0; l < NUM_LINES; l++) begin
      m[pol_idx(l)] = 1'b1;
      if (l < NUM_EDGE) m[mode_idx(l)] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/irq_cond_sync.sv
module irq_cond_sync #(
  parameter int unsigned WIDTH   = 5,
  parameter int unsigned PRE_W   = 4,
  parameter int unsigned STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o,
  output logic [PRE_W-1:0] pre_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < STAGES; s++) stg_q[s] <= RST_VAL;
    end else begin
      stg_q[0] <= d_i;
      for (int s = 1; s < STAGES; s++) stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o   = stg_q[STAGES-1];
  // value the last stage takes on the next edge
  assign pre_o = stg_q[STAGES-2][PRE_W-1:0];
endmodule

// File: rtl/irq_cond_regs.sv
module irq_cond_regs
  import irq_cond_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [ADDR_W-1:0]   addr_i,
  input  logic                we_i,
  input  logic [CTRL_W-1:0]   wdata_i,
  input  logic [NUM_EDGE-1:0] set_i,
  output logic [CTRL_W-1:0]   rdata_o,
  output logic [CTRL_W-1:0]   ctrl_o,
  output logic [NUM_EDGE-1:0] stat_o,
  output logic                ctrl_wr_o
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask();

  logic [CTRL_W-1:0]   ctrl_q;
  logic [NUM_EDGE-1:0] stat_q, clr;
  logic                stat_wr;

  assign ctrl_wr_o = we_i && (addr_i == CTRL_ADDR);
  assign stat_wr   = we_i && (addr_i == STAT_ADDR);
  assign clr       = stat_wr ? wdata_i[NUM_EDGE-1:0] : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      stat_q <= '0;
    end else begin
      if (ctrl_wr_o) ctrl_q <= wdata_i & MASK;
      stat_q <= (stat_q & ~clr) | set_i;  // set wins over clear
    end
  end

  always_comb begin
    rdata_o = '0;
    if (addr_i == CTRL_ADDR)      rdata_o = ctrl_q;
    else if (addr_i == STAT_ADDR) rdata_o[NUM_EDGE-1:0] = stat_q;
  end

  assign ctrl_o = ctrl_q;
  assign stat_o = stat_q;
endmodule

// File: rtl/irq_cond_edge.sv
module irq_cond_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic s_i,
  input  logic s_nxt_i,
  input  logic pol_i,
  input  logic edge_i,
  input  logic reload_i,
  input  logic stat_i,
  output logic set_o,
  output logic prev_o,
  output logic pend_o
);
  logic prev_q;

  // on a control write, align prev with the sample that arrives next
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       prev_q <= 1'b1;
    else if (reload_i) prev_q <= s_nxt_i;
    else               prev_q <= s_i;
  end

  assign set_o  = edge_i && (pol_i ? (s_i && !prev_q) : (!s_i && prev_q));
  assign pend_o = edge_i ? stat_i : (s_i == pol_i);
  assign prev_o = prev_q;
endmodule

// File: rtl/irq_cond.sv
module irq_cond
  import irq_cond_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1),
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_LINES-1:0] irq_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic                 we_i,
  input  logic [CTRL_W-1:0]    wdata_i,
  output logic [CTRL_W-1:0]    rdata_o,
  output logic [NUM_LINES-1:0] pend_o
);
  logic [NUM_LINES-1:0] sync_s;
  logic [NUM_EDGE-1:0]  sync_pre, stat_q, set_s, prev_s;
  logic [CTRL_W-1:0]    ctrl_q;
  logic                 ctrl_wr;

  irq_cond_sync #(
    .WIDTH(NUM_LINES), .PRE_W(NUM_EDGE), .STAGES(SYNC_STAGES), .RST_VAL('1)
  ) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(irq_i), .q_o(sync_s), .pre_o(sync_pre)
  );

  irq_cond_regs #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
    .wdata_i(wdata_i), .set_i(set_s), .rdata_o(rdata_o), .ctrl_o(ctrl_q),
    .stat_o(stat_q), .ctrl_wr_o(ctrl_wr)
  );

  for (genvar l = 0; l < NUM_EDGE; l++) begin : g_edge
    irq_cond_edge u_line (
      .clk_i(clk_i), .rst_ni(rst_ni),
      .s_i(sync_s[l]), .s_nxt_i(sync_pre[l]),
      .pol_i(ctrl_q[pol_idx(l)]), .edge_i(ctrl_q[mode_idx(l)]),
      .reload_i(ctrl_wr), .stat_i(stat_q[l]),
      .set_o(set_s[l]), .prev_o(prev_s[l]), .pend_o(pend_o[l])
    );
  end

  for (genvar l = NUM_EDGE; l < NUM_LINES; l++) begin : g_level
    assign pend_o[l] = (sync_s[l] == ctrl_q[pol_idx(l)]);
  end
endmodule

// File: rtl/irq_cond_chk.sv
module irq_cond_chk
  import irq_cond_pkg::*;
#(
  parameter int unsigned ADDR_W = 2,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = '0,
  parameter logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(1)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [ADDR_W-1:0]    addr_i,
  input logic                 we_i,
  input logic [CTRL_W-1:0]    wdata_i,
  input logic [CTRL_W-1:0]    rdata_o,
  input logic [NUM_LINES-1:0] pend_o,
  input logic [CTRL_W-1:0]    ctrl_q,
  input logic [NUM_EDGE-1:0]  stat_q,
  input logic [NUM_LINES-1:0] sync_s,
  input logic [NUM_EDGE-1:0]  prev_s
);
  localparam logic [CTRL_W-1:0] MASK = ctrl_mask();

  assert_ctrl_reserved_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == CTRL_ADDR) |-> ((rdata_o & ~MASK) == '0));

  for (genvar l = 0; l < NUM_EDGE; l++) begin : g_e
    assert_rise_sets_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[mode_idx(l)] && ctrl_q[pol_idx(l)] && sync_s[l] && !prev_s[l])
      |=> stat_q[l]);
    // covers R8: set holds even with a simultaneous clear
    assert_fall_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ctrl_q[mode_idx(l)] && !ctrl_q[pol_idx(l)] && !sync_s[l] && prev_s[l])
      |=> stat_q[l]);
    assert_status_holds_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_q[l] && !(we_i && addr_i == STAT_ADDR && wdata_i[l])) |=> stat_q[l]);
    assert_level_no_latch_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[mode_idx(l)] && !stat_q[l]) |=> !stat_q[l]);
    assert_level_steady_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ctrl_q[mode_idx(l)] && $stable(ctrl_q) && $stable(sync_s[l]))
      |-> $stable(pend_o[l]));
  end

  for (genvar l = NUM_EDGE; l < NUM_LINES; l++) begin : g_l
    assert_fixed_level_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($stable(ctrl_q[pol_idx(l)]) && $stable(sync_s[l])) |-> $stable(pend_o[l]));
  end
endmodule

bind irq_cond irq_cond_chk #(
  .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .STAT_ADDR(STAT_ADDR)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .we_i(we_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .pend_o(pend_o), .ctrl_q(ctrl_q),
  .stat_q(stat_q), .sync_s(sync_s), .prev_s(prev_s)
);

// File: tb/tb_irq_cond.sv
module tb_irq_cond;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  irq_i = '1;
  logic [1:0]  addr_i = '0;
  logic        we_i = 1'b0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [4:0]  pend_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  irq_cond dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_i(irq_i), .addr_i(addr_i),
    .we_i(we_i), .wdata_i(wdata_i), .rdata_o(rdata_o), .pend_o(pend_o)
  );

  always #10 clk_i = ~clk_i;

  task automatic tick();
    @(posedge clk_i); #1;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    addr_i = a; wdata_i = d; we_i = 1'b1;
    tick();
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    addr_i = a; #1; d = rdata_o;
  endtask

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_line(input string req, input int i, input logic exp);
    chk(req, {15'd0, pend_o[i]}, {15'd0, exp});
  endtask

  initial begin
    logic [15:0] v;
    logic idle;
    logic [15:0] c;
    repeat (3) tick();
    rst_ni = 1'b1;
    tick();

    // R1 reset state
    rd(2'd0, v); chk("R1 ctrl", v, 16'h0000);
    rd(2'd1, v); chk("R1 stat", v, 16'h0000);
    chk("R1 pend", {11'd0, pend_o}, 16'h0000);

    // R2 writable field sweep
    wr(2'd0, 16'hFFFF); rd(2'd0, v); chk("R2 all", v, 16'hFF80);
    for (int b = 0; b < 16; b++) begin
      wr(2'd0, 16'(1) << b); rd(2'd0, v);
      chk("R2 bit", v, (16'(1) << b) & 16'hFF80);
    end

    // R3 level sweep, all pin patterns, both polarities (R10 for line 4)
    for (int p = 0; p < 2; p++) begin
      wr(2'd0, (p != 0) ? 16'hF080 : 16'h0000);
      for (int pat = 0; pat < 32; pat++) begin
        irq_i = 5'(pat);
        tick(); tick();
        chk("R3 level", {11'd0, pend_o}, {11'd0, (p != 0) ? 5'(pat) : ~5'(pat)});
      end
    end

    // R4/R5/R6/R9 per edge line, both polarities
    for (int i = 0; i < 4; i++) begin
      for (int p = 0; p < 2; p++) begin
        c = (16'(1) << (11 - i)) | (16'(p) << (15 - i));
        idle = (p == 0);
        wr(2'd0, c);
        irq_i = {5{idle}};
        repeat (3) tick();
        wr(2'd1, 16'h000F);
        chk_line("R4/R5 quiet", i, 1'b0);
        irq_i[i] = ~idle;
        tick(); tick();
        chk_line("R4/R5 latency", i, 1'b0);
        tick();
        chk_line(p != 0 ? "R4 rise" : "R5 fall", i, 1'b1);
        rd(2'd1, v); chk("R6 stat read", v, 16'(1) << i);
        irq_i[i] = idle;
        repeat (3) tick();
        chk_line("R6 hold", i, 1'b1);
        wr(2'd1, ~(16'(1) << i));
        chk_line("R6 write0", i, 1'b1);
        wr(2'd1, 16'(1) << i);
        chk_line("R6 clear", i, 1'b0);
        wr(2'd0, c ^ (16'(1) << (15 - i)));
        repeat (3) tick();
        chk_line("R9 pol flip", i, 1'b0);
        irq_i[i] = ~idle;
        repeat (3) tick();
        chk_line(p != 0 ? "R5 wrong dir" : "R4 wrong dir", i, 1'b0);
        irq_i[i] = idle;
        repeat (3) tick();
        chk_line(p != 0 ? "R5 fall" : "R4 rise", i, 1'b1);
      end
    end

    // R8 set wins over a simultaneous clear (line 0, rising)
    wr(2'd0, 16'h8800);
    irq_i = 5'b11110;
    repeat (3) tick();
    wr(2'd1, 16'h000F);
    irq_i[0] = 1'b1; repeat (3) tick();
    irq_i[0] = 1'b0; repeat (3) tick();
    chk_line("R8 preset", 0, 1'b1);
    irq_i[0] = 1'b1;
    tick(); tick();
    wr(2'd1, 16'h0001);
    chk_line("R8 set wins", 0, 1'b1);
    wr(2'd1, 16'h0001);
    chk_line("R8 later clear", 0, 1'b0);

    // R7/R10 line 4 with all mode bits set
    wr(2'd0, 16'h0F80);
    irq_i = 5'b11111;
    tick(); tick();
    chk_line("R10 level", 4, 1'b1);
    wr(2'd1, 16'hFFFF);
    chk_line("R7 stat write", 4, 1'b1);
    irq_i[4] = 1'b0;
    tick(); tick();
    chk_line("R10 follows", 4, 1'b0);

    // R7 level line 0 unaffected by status write
    wr(2'd0, 16'h0000);
    irq_i = 5'b11110;
    tick(); tick();
    chk_line("R7 level on", 0, 1'b1);
    wr(2'd1, 16'h000F);
    chk_line("R7 after clear", 0, 1'b1);

    // R11 level toggles never latch
    irq_i[0] = 1'b1; repeat (3) tick();
    irq_i[0] = 1'b0; repeat (3) tick();
    irq_i[0] = 1'b1; repeat (3) tick();
    rd(2'd1, v); chk("R11 no latch", v, 16'h0000);
    chk_line("R11 pend", 0, 1'b0);

    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule